// File: doc/BRIEF.md
# Monitor Event Sampling Selector

This block decides, for every event that the event builder finishes, whether a copy of that event should also be written into a monitoring buffer. An event is offered with a single-cycle done strobe and its 24-bit event number. The selector answers one clock later with a one-cycle capture strobe, and it keeps a running total of the events it has captured. The capture buffer and the host readout path belong to other blocks.

There are two selection methods, and one flag in a single 32-bit configuration register chooses between them. In prescale mode the selector keeps one event out of every S+1 offered events, where S is a 16-bit field. In event-number mode it keeps only the events whose low event-number bits are all zero. A 4-bit code sets how many low bits must be zero: from 20 bits for code 0 down to 5 bits for code 15. While the downstream buffer reports full, no capture is issued, but the event still counts toward the prescale. The register reads back as it was written, with the top byte forced to zero.

Top module: `evt_mon_sampler`

## Requirements
- R1: After a synchronous reset, the configuration readback is 0 (prescale mode with S = 0), the capture strobe is low and the capture total is 0.
- R2: A register write stores bits 23..0 of the write data. The readback the cycle after the write shows those 24 bits in place, and bits 31..24 always read as zero.
- R3: In prescale mode (bit 23 = 0), S is taken from bits 15..0. Counting from the last write, the selector captures the (S+1)-th offered event, then every (S+1)-th event after that. With S = 0 it captures every event.
- R4: Any register write restarts the prescale count, so the next capture is the (S+1)-th event offered after the write. If an event is offered in the same cycle as a write, the event is judged against the old settings and the count still restarts.
- R5: When bit 23 = 1, the code c in bits 22..19 selects event-number mode. An event is captured only if event-number bits (19-c)..0 are all zero: 20 bits for c = 0, 5 bits for c = 15. Higher event-number bits and the value of S have no effect.
- R6: Write bits 18..16 are stored for readback but have no effect on which events are captured.
- R7: An event offered while the buffer-full input is high is never captured. In prescale mode it still advances the prescale count as if it had been offered normally.
- R8: The capture strobe rises in the cycle after the event-done strobe of a kept event and lasts one cycle for each kept event.
- R9: The capture total increases by one with each capture strobe. It returns to zero on the cycle after the counter-clear input is high, and the clear takes precedence over a capture in the same cycle.
- R10: No capture strobe appears unless an event was offered in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_clr | input | 1 | Clears the capture total |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| evt_done | input | 1 | One-cycle strobe: an event has been built |
| evt_num | input | 24 | Event number of the offered event |
| buf_full | input | 1 | Monitoring buffer is full |
| cap_strobe | output | 1 | Capture this event (one cycle after evt_done) |
| cap_total | output | 32 | Number of events captured since the last clear |

## Verification
The assertions assume that evt_done is a strobe whose event number and buffer-full level are valid in the same cycle. They also assume that the counter clear and a register write are ordinary single-cycle inputs, sampled like the rest. The bench drives every input at the falling edge and holds it for exactly one cycle. Events are spaced one per two cycles, except where back-to-back behaviour is the point of the test. The bench reads the strobe at the following falling edge, so each event's answer is observed before the next event is applied.

// File: rtl/evt_mon_pkg.sv
package evt_mon_pkg;
  // field positions are fixed: software and the readback depend on them
  localparam int MS_REG_W     = 32;
  localparam int MS_CFG_W     = 24;
  localparam int MS_MODE_BIT  = 23;
  localparam int MS_CODE_LSB  = 19;
  localparam int MS_CODE_W    = 4;
  localparam int MS_SCALE_W   = 16;
  localparam int MS_ZERO_MAX  = 20;

  typedef struct packed {
    logic                  evn_mode;
    logic [MS_CODE_W-1:0]  code;
    logic [2:0]            spare;
    logic [MS_SCALE_W-1:0] scale;
  } ms_cfg_t;
endpackage

// File: rtl/evt_mon_cfg.sv
module evt_mon_cfg
  import evt_mon_pkg::*;
#(
  parameter int REG_W = MS_REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output ms_cfg_t          cfg
);
  localparam int PAD_W = REG_W - MS_CFG_W;

  ms_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= '0;
    else if (we) cfg_q <= ms_cfg_t'(wdata[MS_CFG_W-1:0]);
  end

  assign cfg   = cfg_q;
  assign rdata = {{PAD_W{1'b0}}, cfg_q};
endmodule

// File: rtl/evt_mon_prescale.sv
module evt_mon_prescale #(
  parameter int SCALE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic               step,
  input  logic [SCALE_W-1:0] scale,
  output logic               hit
);
  logic [SCALE_W-1:0] pos_q;

  assign hit = (pos_q == scale);

  always_ff @(posedge clk) begin
    if (rst || restart) pos_q <= '0;
    else if (step)      pos_q <= hit ? '0 : pos_q + 1'b1;
  end
endmodule

// File: rtl/evt_mon_evn_match.sv
module evt_mon_evn_match #(
  parameter int EVN_W    = 24,
  parameter int CODE_W   = 4,
  parameter int ZERO_MAX = 20
) (
  input  logic [EVN_W-1:0]  evt_num,
  input  logic [CODE_W-1:0] code,
  output logic              keep
);
  localparam int SPAN_W = $clog2(ZERO_MAX + 1) + 1;

  logic [SPAN_W-1:0] span;
  logic [EVN_W-1:0]  mask;

  assign span = SPAN_W'(ZERO_MAX) - SPAN_W'(code);

  for (genvar i = 0; i < EVN_W; i++) begin : g_mask
    assign mask[i] = (SPAN_W'(i) < span) && (i < ZERO_MAX);
  end

  assign keep = ~|(evt_num & mask);
endmodule

// File: rtl/evt_mon_capture.sv
module evt_mon_capture #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_clr,
  input  logic             take,
  output logic             strobe,
  output logic [CNT_W-1:0] total
);
  always_ff @(posedge clk) begin
    if (rst) strobe <= 1'b0;
    else     strobe <= take;
  end

  always_ff @(posedge clk) begin
    if (rst || cnt_clr) total <= '0;
    else if (take)      total <= total + 1'b1;
  end
endmodule

// File: rtl/evt_mon_sampler.sv
module evt_mon_sampler
  import evt_mon_pkg::*;
#(
  parameter int REG_W    = MS_REG_W,
  parameter int EVN_W    = 24,
  parameter int CNT_W    = 32,
  parameter int ZERO_MAX = MS_ZERO_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_clr,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             evt_done,
  input  logic [EVN_W-1:0] evt_num,
  input  logic             buf_full,
  output logic             cap_strobe,
  output logic [CNT_W-1:0] cap_total
);
  ms_cfg_t cfg;
  logic    ps_hit, evn_keep, keep, take;

  evt_mon_cfg #(.REG_W(REG_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg)
  );

  evt_mon_prescale #(.SCALE_W(MS_SCALE_W)) u_ps (
    .clk(clk), .rst(rst), .restart(cfg_we),
    .step(evt_done && !cfg.evn_mode), .scale(cfg.scale), .hit(ps_hit)
  );

  evt_mon_evn_match #(.EVN_W(EVN_W), .CODE_W(MS_CODE_W), .ZERO_MAX(ZERO_MAX)) u_evn (
    .evt_num(evt_num), .code(cfg.code), .keep(evn_keep)
  );

  assign keep = cfg.evn_mode ? evn_keep : ps_hit;
  assign take = evt_done && keep && !buf_full;

  evt_mon_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .cnt_clr(cnt_clr), .take(take),
    .strobe(cap_strobe), .total(cap_total)
  );
endmodule

// File: rtl/evt_mon_sampler_chk.sv
module evt_mon_sampler_chk #(
  parameter int REG_W = 32,
  parameter int EVN_W = 24,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_clr,
  input logic             cfg_we,
  input logic [REG_W-1:0] cfg_wdata,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             evt_done,
  input logic [EVN_W-1:0] evt_num,
  input logic             buf_full,
  input logic             cap_strobe,
  input logic [CNT_W-1:0] cap_total
);
  AST_TOP_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[31:24] == 8'h00);  // R2
  AST_READBACK: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata[23:0] == $past(cfg_wdata[23:0]));  // R2
  AST_EVN_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    (evt_done && cfg_rdata[23] && evt_num[4:0] != 5'd0) |=> !cap_strobe);  // R5
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    buf_full |=> !cap_strobe);  // R7
  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (rst)
    (cap_strobe && !$past(cnt_clr)) |-> cap_total == $past(cap_total) + 1'b1);  // R9
  AST_TOTAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> cap_total == '0);  // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !evt_done |=> !cap_strobe);  // R10
endmodule

bind evt_mon_sampler evt_mon_sampler_chk #(
  .REG_W(REG_W), .EVN_W(EVN_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/evt_mon_sampler_bench.sv
module evt_mon_sampler_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_clr = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        evt_done = 1'b0;
  logic [23:0] evt_num = '0;
  logic        buf_full = 1'b0;
  logic        cap_strobe;
  logic [31:0] cap_total;

  int checks = 0;
  int fails  = 0;
  int exp_total = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  evt_mon_sampler u_evt_mon_sampler (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // offer one event, return strobe seen in following cycle
  task automatic offer(input logic [23:0] n, input logic full, output logic got);
    evt_done = 1'b1; evt_num = n; buf_full = full;
    @(negedge clk);
    evt_done = 1'b0; buf_full = 1'b0;
    got = cap_strobe;
    if (got) exp_total++;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 rdata", cfg_rdata, 32'h0);
    check("R1 strobe", {31'b0, cap_strobe}, 32'h0);
    check("R1 total", cap_total, 32'h0);
  endtask

  task automatic t_readback();
    wr(32'hFFFF_FFFF);
    check("R2 all ones", cfg_rdata, 32'h00FF_FFFF);
    wr(32'h1234_5678);
    check("R2 pattern", cfg_rdata, 32'h0034_5678);
  endtask

  task automatic t_prescale();
    logic g;
    wr(32'h0000_0002);
    for (int i = 1; i <= 9; i++) begin
      offer(24'(i), 1'b0, g);
      check("R3 S=2", {31'b0, g}, {31'b0, (i % 3) == 0});
    end
    wr(32'h0000_0000);
    for (int i = 0; i < 3; i++) begin
      offer(24'(i + 7), 1'b0, g);
      check("R3 S=0", {31'b0, g}, 32'h1);
    end
  endtask

  task automatic t_restart();
    logic g;
    wr(32'h0000_0003);
    offer(24'd1, 1'b0, g);
    offer(24'd2, 1'b0, g);
    wr(32'h0000_0003);
    for (int i = 1; i <= 4; i++) begin
      offer(24'(i), 1'b0, g);
      check("R4 restart", {31'b0, g}, {31'b0, i == 4});
    end
  endtask

  task automatic t_evn();
    logic g;
    wr(32'h00F8_0000);  // code 15: 5 low bits
    offer(24'h000020, 1'b0, g); check("R5 c15 keep", {31'b0, g}, 32'h1);
    offer(24'h000010, 1'b0, g); check("R5 c15 drop", {31'b0, g}, 32'h0);
    wr(32'h0080_0000);  // code 0: 20 low bits
    offer(24'h100000, 1'b0, g); check("R5 c0 keep", {31'b0, g}, 32'h1);
    offer(24'hF00000, 1'b0, g); check("R5 c0 high bits", {31'b0, g}, 32'h1);
    offer(24'h080000, 1'b0, g); check("R5 c0 drop", {31'b0, g}, 32'h0);
    wr(32'h00D0_FFFF);  // code 10: 10 low bits, S ignored
    offer(24'h000400, 1'b0, g); check("R5 c10 keep", {31'b0, g}, 32'h1);
    offer(24'h000200, 1'b0, g); check("R5 c10 drop", {31'b0, g}, 32'h0);
  endtask

  task automatic t_spare();
    logic g;
    wr(32'h00A7_0000);  // code 4 (16 bits) with spare bits set
    offer(24'h010000, 1'b0, g); check("R6 evn keep", {31'b0, g}, 32'h1);
    offer(24'h008000, 1'b0, g); check("R6 evn drop", {31'b0, g}, 32'h0);
    wr(32'h0007_0001);  // prescale S=1 with spare bits set
    for (int i = 1; i <= 4; i++) begin
      offer(24'(i), 1'b0, g);
      check("R6 prescale", {31'b0, g}, {31'b0, (i % 2) == 0});
    end
  endtask

  task automatic t_full();
    logic g;
    wr(32'h0000_0001);
    offer(24'd1, 1'b0, g); check("R7 ev1", {31'b0, g}, 32'h0);
    offer(24'd2, 1'b1, g); check("R7 full", {31'b0, g}, 32'h0);
    offer(24'd3, 1'b0, g); check("R7 ev3", {31'b0, g}, 32'h0);
    offer(24'd4, 1'b0, g); check("R7 ev4", {31'b0, g}, 32'h1);
    wr(32'h00F8_0000);
    offer(24'h000040, 1'b1, g); check("R7 evn full", {31'b0, g}, 32'h0);
  endtask

  task automatic t_pulse();
    wr(32'h0000_0000);
    evt_done = 1'b1; evt_num = 24'd5;
    @(negedge clk);
    check("R8 rise", {31'b0, cap_strobe}, 32'h1);
    evt_num = 24'd6;
    @(negedge clk);
    evt_done = 1'b0;
    check("R8 back to back", {31'b0, cap_strobe}, 32'h1);
    exp_total += 2;
    @(negedge clk);
    check("R8 one cycle", {31'b0, cap_strobe}, 32'h0);
    @(negedge clk);
    check("R10 idle", {31'b0, cap_strobe}, 32'h0);
  endtask

  task automatic t_total();
    logic g;
    check("R9 running total", cap_total, 32'(exp_total));
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    check("R9 cleared", cap_total, 32'h0);
    exp_total = 0;
    wr(32'h0000_0000);
    offer(24'd1, 1'b0, g);
    offer(24'd2, 1'b0, g);
    check("R9 recount", cap_total, 32'h2);
    cnt_clr = 1'b1; evt_done = 1'b1; evt_num = 24'd3;
    @(negedge clk);
    cnt_clr = 1'b0; evt_done = 1'b0;
    check("R9 clear wins", cap_total, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_readback();
    t_prescale();
    t_restart();
    t_evn();
    t_spare();
    t_full();
    t_pulse();
    t_total();
    finished = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule